// File: doc/BRIEF.md
# Power-Good and Die-Temperature Supervisor

This block sits beside the startup sequencer of a boost regulator. It holds an active-high power-good flag, which stands in for an open-drain status pin: 1 means good and 0 means fault. The flag goes high only after the sequencer reports a finished soft-start while nothing is wrong. It drops at once when a fault is raised, when the enable input falls, or while the regulator is coming back from forced bypass.

The block also reads a digital die-temperature code in degrees Celsius and keeps two latched flags, each with hysteresis. The warning flag only masks power-good; regulation continues. The shutdown flag asks the sequencer to stop the regulator. Restart is allowed again only after the die has cooled below the shutdown flag's clear level, and a new soft-start is then needed before power-good returns.

Top module: `pg_thermal_sup`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, pwr_good is 0, thermal_shdn is 0 and restart_ok is 1.
- R2: A one-cycle ss_done pulse arms the sequence latch when enable is 1 and fault_active, fb_exit_active and the shutdown flag are all 0. pwr_good then reads 1 from the next cycle, as long as no masking condition holds.
- R3: fault_active = 1 drives pwr_good to 0 in the same cycle and clears the sequence latch. pwr_good stays 0 after the fault ends until a new ss_done arrives.
- R4: A temperature code above WARN_HI (default 125) sets the warning flag at the next clock edge, and pwr_good reads 0 while that flag is set. A code at or below WARN_LO (default 105) clears the flag, and pwr_good returns without a new soft-start if the sequence latch is still armed.
- R5: A temperature code above SHDN_HI (default 150) sets thermal_shdn at the next clock edge. thermal_shdn clears at the edge after a code at or below SHDN_LO (default 130). restart_ok is always the inverse of thermal_shdn.
- R6: A thermal shutdown forces pwr_good to 0 and clears the sequence latch, so pwr_good needs a new ss_done once the die has cooled.
- R7: fb_exit_active = 1 forces pwr_good to 0 and clears the sequence latch. An ss_done pulse seen while fb_exit_active is 1 is ignored.
- R8: enable = 0 forces pwr_good to 0 and clears the sequence latch. An ss_done pulse seen while enable is 0 is ignored.
- R9: A temperature code strictly between a flag's clear level and its set level, or equal to the set level, leaves that flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Regulator enable; 0 means shutdown |
| ss_done | input | 1 | One-cycle pulse from the sequencer when soft-start has finished |
| fault_active | input | 1 | The sequencer is in a fault state |
| fb_exit_active | input | 1 | The regulator is leaving forced bypass toward boost |
| temp_code | input | TEMP_W | Die temperature in °C, unsigned |
| pwr_good | output | 1 | 1 = good, 0 = fault |
| thermal_shdn | output | 1 | Over-temperature shutdown request |
| restart_ok | output | 1 | The die is cool enough for the sequencer to restart |

## Verification
The assertions check these rules on every cycle: a fault, a low enable or an over-warning temperature always gives a low pwr_good on the next cycle; a code above the shutdown level always raises thermal_shdn; restart_ok always opposes thermal_shdn; and a code inside the shutdown hysteresis band never moves that flag. Some behaviours only the bench scenarios can show. These are the need for a fresh soft-start after a fault, a forced-bypass exit or a thermal shutdown, the return of pwr_good without a new soft-start when only the warning clears, and the exact boundary codes at each set and clear level.

// File: rtl/pg_thermal_sup.sv
module pg_thermal_sup #(
  parameter int TEMP_W  = 8,
  parameter int WARN_HI = 125,
  parameter int WARN_LO = 105,
  parameter int SHDN_HI = 150,
  parameter int SHDN_LO = 130
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              ss_done,
  input  logic              fault_active,
  input  logic              fb_exit_active,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              pwr_good,
  output logic              thermal_shdn,
  output logic              restart_ok
);
  localparam logic [TEMP_W-1:0] W_HI = TEMP_W'(WARN_HI);
  localparam logic [TEMP_W-1:0] W_LO = TEMP_W'(WARN_LO);
  localparam logic [TEMP_W-1:0] S_HI = TEMP_W'(SHDN_HI);
  localparam logic [TEMP_W-1:0] S_LO = TEMP_W'(SHDN_LO);

  logic warn_q, shdn_q, seq_q;

  wire seq_kill = !enable || fault_active || fb_exit_active || shdn_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                warn_q <= 1'b0;
    else if (temp_code > W_HI) warn_q <= 1'b1;
    else if (temp_code <= W_LO) warn_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                shdn_q <= 1'b0;
    else if (temp_code > S_HI) shdn_q <= 1'b1;
    else if (temp_code <= S_LO) shdn_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        seq_q <= 1'b0;
    else if (seq_kill) seq_q <= 1'b0;
    else if (ss_done)  seq_q <= 1'b1;

  assign pwr_good     = seq_q && !seq_kill && !warn_q;
  assign thermal_shdn = shdn_q;
  assign restart_ok   = !shdn_q;
endmodule

module pg_thermal_sup_chk #(
  parameter int TEMP_W  = 8,
  parameter int WARN_HI = 125,
  parameter int SHDN_HI = 150,
  parameter int SHDN_LO = 130
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              fault_active,
  input logic [TEMP_W-1:0] temp_code,
  input logic              pwr_good,
  input logic              thermal_shdn,
  input logic              restart_ok
);
  localparam logic [TEMP_W-1:0] W_HI = TEMP_W'(WARN_HI);
  localparam logic [TEMP_W-1:0] S_HI = TEMP_W'(SHDN_HI);
  localparam logic [TEMP_W-1:0] S_LO = TEMP_W'(SHDN_LO);

  // R3
  fault_drops_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_active |=> !pwr_good);
  // R8
  disable_drops_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pwr_good);
  // R4
  warn_masks_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code > W_HI) |=> !pwr_good);
  // R5
  shdn_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code > S_HI) |=> thermal_shdn);
  // R5
  restart_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_ok != thermal_shdn);
  // R6
  shdn_rise_pg_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thermal_shdn) |-> !pwr_good);
  // R9
  shdn_band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code > S_LO && temp_code <= S_HI) |=> $stable(thermal_shdn));
endmodule

bind pg_thermal_sup pg_thermal_sup_chk #(
  .TEMP_W(TEMP_W), .WARN_HI(WARN_HI), .SHDN_HI(SHDN_HI), .SHDN_LO(SHDN_LO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .fault_active(fault_active),
  .temp_code(temp_code), .pwr_good(pwr_good), .thermal_shdn(thermal_shdn),
  .restart_ok(restart_ok)
);

// File: tb/pg_thermal_sup_tb.sv
module pg_thermal_sup_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WHI = 125, WLO = 105, SHI = 150, SLO = 130;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, ss_done = 1'b0, fault_active = 1'b0, fb_exit_active = 1'b0;
  logic [7:0] temp_code = 8'd40;
  logic pwr_good, thermal_shdn, restart_ok;

  int n_chk = 0, n_bad = 0;
  bit m_warn, m_shdn, m_seq;

  always #(CLK_PERIOD/2) clk = ~clk;

  pg_thermal_sup dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ss_done(ss_done),
    .fault_active(fault_active), .fb_exit_active(fb_exit_active),
    .temp_code(temp_code), .pwr_good(pwr_good), .thermal_shdn(thermal_shdn),
    .restart_ok(restart_ok)
  );

  function automatic bit hyst(bit cur, int t, int hi, int lo);
    if (t > hi) return 1'b1;
    if (t <= lo) return 1'b0;
    return cur;
  endfunction

  function automatic bit kill_now();
    return !enable || fault_active || fb_exit_active || m_shdn;
  endfunction

  function automatic bit exp_pg();
    return m_seq && !kill_now() && !m_warn;
  endfunction

  task automatic chk(bit got, bit exp, string tag, string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic cyc(bit en, bit ss, bit flt, bit fb, int t, string tag);
    @(negedge clk);
    enable = en; ss_done = ss; fault_active = flt; fb_exit_active = fb;
    temp_code = 8'(t);
    #1;
    chk(pwr_good, exp_pg(), tag, "pwr_good");
    chk(thermal_shdn, m_shdn, "R5", "thermal_shdn");
    chk(restart_ok, !m_shdn, "R5", "restart_ok");
    if (kill_now()) m_seq = 1'b0; else if (ss) m_seq = 1'b1;
    m_warn = hyst(m_warn, t, WHI, WLO);
    m_shdn = hyst(m_shdn, t, SHI, SLO);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int t;
    void'($urandom(32'd2024));
    m_warn = 0; m_shdn = 0; m_seq = 0;
    repeat (3) @(negedge clk);
    chk(pwr_good, 1'b0, "R1", "pwr_good in reset");
    chk(thermal_shdn, 1'b0, "R1", "thermal_shdn in reset");
    chk(restart_ok, 1'b1, "R1", "restart_ok in reset");
    rst_n = 1'b1;
    cyc(1, 0, 0, 0, 60, "R1");
    cyc(1, 1, 0, 0, 60, "R2");
    cyc(1, 0, 0, 0, 60, "R2");          // latch armed
    cyc(1, 0, 1, 0, 60, "R3");          // same-cycle drop
    cyc(1, 0, 0, 0, 60, "R3");          // still low after fault
    cyc(0, 1, 0, 0, 60, "R8");          // ss ignored when disabled
    cyc(1, 0, 0, 0, 60, "R8");
    cyc(1, 1, 0, 1, 60, "R7");          // ss ignored in bypass exit
    cyc(1, 0, 0, 0, 60, "R7");
    cyc(1, 1, 0, 0, 125, "R2");
    cyc(1, 0, 0, 0, 126, "R4");         // 125 is not above the set level
    cyc(1, 0, 0, 0, 106, "R4");         // warning now set
    cyc(1, 0, 0, 0, 105, "R9");         // 106 held the flag
    cyc(1, 0, 0, 0, 105, "R4");         // returns without soft-start
    cyc(1, 0, 0, 0, 150, "R4");
    cyc(1, 0, 0, 0, 151, "R9");
    cyc(1, 0, 0, 0, 131, "R6");
    cyc(1, 1, 0, 0, 130, "R6");         // ss ignored in shutdown
    cyc(1, 0, 0, 0, 100, "R6");
    cyc(1, 0, 0, 0, 100, "R6");         // latch was cleared
    cyc(1, 1, 0, 0, 100, "R2");
    cyc(1, 0, 0, 0, 100, "R2");
    t = 100;
    for (int i = 0; i < 4000; i++) begin
      bit en, ss, flt, fb;
      if ($urandom_range(0, 99) < 3) t = $urandom_range(20, 200);
      else t = t + $urandom_range(0, 10) - 5;
      if (t < 0) t = 0;
      if (t > 255) t = 255;
      en  = $urandom_range(0, 99) < 95;
      ss  = $urandom_range(0, 99) < 10;
      flt = $urandom_range(0, 99) < 4;
      fb  = $urandom_range(0, 99) < 4;
      cyc(en, ss, flt, fb, t, "R2");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule